// File: doc/BRIEF.md
# Three-Wire RTC Burst-Read Sequencer

This block reads the complete clock and calendar register set from a serial real-time-clock device in one burst. The device uses three wires: a chip enable, a serial clock, and a single data line that both sides take turns driving. One active-low trigger pulse on `trig_n` starts a transaction. The block raises chip enable and divides the system clock down to a serial clock. It shifts out a fixed read-burst command byte, least-significant bit first. It then stops driving the data line and shifts in a 64-bit reply over the next 64 serial clock pulses.

The received bits build up in a shift chain that cannot be seen at the outputs. When the last pulse ends, the whole chain is copied into an output latch in one step, so a display reading `rd_data` never sees partial data. Each of the eight output bytes has its own active-low enable, so a display multiplexer can select one byte at a time.

The data line appears at the ports as a value (`dq_out`), a drive enable (`dq_oe`) and a sampled input (`dq_in`). The pad-level tri-state buffer sits outside the block.

Top module: `rtc_burst_reader`

## Requirements
- R1: After reset, `ce`, `sclk`, `dq_oe` and `busy` are low and every bit of `rd_data` is zero.
- R2: A falling edge on `trig_n` arms the block, and `busy` is high in the next cycle. The following rising edge on `trig_n` starts the transaction, and `ce` is high in the cycle after that rising edge is sampled.
- R3: A transaction has exactly 72 rising edges of `sclk`. Each serial clock period is `CLK_DIV` system clocks. `ce` stays high for exactly 72 × `CLK_DIV` system clocks, and `sclk` is never high while `ce` is low.
- R4: The command shifted out is 8'hBF, least-significant bit first, with bit n valid at rising edge n+1 of `sclk`. `dq_out` changes only while `sclk` is low.
- R5: `dq_oe` is high at `sclk` rising edges 1 to 8. It falls in the same cycle as the 9th rising edge and stays low to the end. It is never high while `ce` is low.
- R6: The reply bit sampled at `sclk` rising edge 9+j (j = 0..63) appears at `rd_data[j]`, so reply byte k occupies `rd_data[8k+7:8k]` with its first-received bit at the lowest position.
- R7: `rd_data` does not change during a transaction. It takes the new reply in the cycle after the 72nd serial clock pulse ends, which is the same cycle in which `ce` and `busy` fall.
- R8: `byte_oe_n[k]` high forces `rd_data[8k+7:8k]` to zero. Low shows the latched byte. The select takes effect combinationally, without changing the latched data.
- R9: Trigger edges during a running transaction are ignored. That transaction still has 72 pulses, and no new transaction follows it.
- R10: `busy` is high from the armed cycle until the end of the 72nd pulse and is always high while `ce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_n | input | 1 | Active-low start pulse, synchronous to `clk` |
| byte_oe_n | input | 8 | Active-low per-byte output enables |
| dq_in | input | 1 | Sampled level of the shared data line |
| ce | output | 1 | Chip enable to the clock device |
| sclk | output | 1 | Serial clock to the clock device |
| dq_out | output | 1 | Value to drive on the shared data line |
| dq_oe | output | 1 | Drive enable for the shared data line |
| busy | output | 1 | Transaction armed or in progress |
| rd_data | output | 64 | Latched reply bytes, gated by `byte_oe_n` |

## Verification
The checker checks the following on every cycle:
- the serial clock and the line drive are gated by chip enable;
- `busy` covers chip enable;
- `dq_out` is steady while `sclk` is high;
- the line is released only on a rising serial clock;
- the output latch stays frozen during a transaction;
- a transaction ends only after exactly 72 rising edges.

Only the bench scenarios can show the command byte's value and bit order, the mapping of reply bits into bytes, the per-byte gating of known data, and that a trigger inside a running transaction leaves the pulse count and the following idle time unchanged.

// File: rtl/rtc_burst_pkg.sv
`timescale 1ns/1ps
// Package: rtc_burst_pkg
// Shared defaults and the controller state type for the three-wire RTC
// burst reader. Assumes one synchronous clock domain.
package rtc_burst_pkg;

    // Default read-burst command issued at the start of each transaction.
    localparam logic [7:0] RTC_BURST_CMD = 8'hBF;

    // Default number of command bits and reply bytes.
    localparam int RTC_CMD_BITS   = 8;
    localparam int RTC_REPLY_BYTES = 8;

    // Controller state: idle, armed by trigger fall, or clocking the bus.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } rtc_state_e;

endpackage

// File: rtl/rtc_sclk_gen.sv
`timescale 1ns/1ps
// Module: rtc_sclk_gen
// Divides the system clock into the serial clock while `run` is high.
// Produces one-cycle strobes in the cycle before sclk rises and before it
// falls, so downstream registers change on the same edge as sclk.
// Assumes CLK_DIV is even and at least 4; sclk idles low.
module rtc_sclk_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] RISE_AT = DIV_W'(CLK_DIV / 2 - 1);
    localparam logic [DIV_W-1:0] FALL_AT = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;
    logic             sclk_q;

    assign rise_tick = run && (div_cnt == RISE_AT);
    assign fall_tick = run && (div_cnt == FALL_AT);
    assign sclk      = sclk_q;

    // Phase counter: wraps once per serial clock period, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
        end else if (div_cnt == FALL_AT) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Serial clock register: high for the second half of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sclk_q <= 1'b0;
        end else if (rise_tick) begin
            sclk_q <= 1'b1;
        end else if (fall_tick) begin
            sclk_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_pulse_seq.sv
`timescale 1ns/1ps
// Module: rtc_pulse_seq
// Counts serial clock pulses in a transaction and decodes the pulse numbers
// that switch the command shift, the bus turnaround, the reply sampling and
// the terminal count. Assumes the count is cleared whenever `run` is low.
module rtc_pulse_seq #(
    parameter int CMD_W   = 8,
    parameter int N_BYTES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise_tick,
    input  logic fall_tick,
    output logic shift_en,
    output logic turn_en,
    output logic sample_en,
    output logic done
);
    localparam int TOTAL  = CMD_W + 8 * N_BYTES;
    localparam int PCNT_W = $clog2(TOTAL + 1);
    localparam logic [PCNT_W-1:0] CMD_LAST  = PCNT_W'(CMD_W);
    localparam logic [PCNT_W-1:0] PULSE_END = PCNT_W'(TOTAL);

    logic [PCNT_W-1:0] pulse_cnt;

    // Pulse counter: increments on every serial clock rise of the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pulse_cnt <= '0;
        end else if (rise_tick) begin
            pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    // Next command bit is presented after falls 1..CMD_W-1.
    assign shift_en  = fall_tick && (pulse_cnt < CMD_LAST);
    // The rise that begins pulse CMD_W+1 hands the line to the peripheral.
    assign turn_en   = rise_tick && (pulse_cnt == CMD_LAST);
    // Every rise from pulse CMD_W+1 onward samples one reply bit.
    assign sample_en = rise_tick && (pulse_cnt >= CMD_LAST);
    // Terminal count: the fall that ends the last pulse.
    assign done      = fall_tick && (pulse_cnt == PULSE_END);

endmodule

// File: rtl/rtc_cmd_shifter.sv
`timescale 1ns/1ps
// Module: rtc_cmd_shifter
// Holds the command byte, shifts it out LSB first, and owns the registered
// direction flag (line drive enable). Outputs are registers, so neither the
// data value nor the enable glitches at the turnaround.
// Assumes `load` and `start` never occur in the same cycle.
module rtc_cmd_shifter #(
    parameter int         CMD_W    = 8,
    parameter logic [7:0] CMD_CODE = 8'hBF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic start,
    input  logic shift_en,
    input  logic turn_en,
    input  logic done,
    output logic dq_out,
    output logic dq_oe
);
    logic [CMD_W-1:0] cmd_sr;
    logic             dq_q;
    logic             oe_q;

    assign dq_out = dq_q;
    assign dq_oe  = oe_q;

    // Command register: parallel load on trigger fall, shift right per bit sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sr <= '0;
        end else if (load) begin
            cmd_sr <= CMD_W'(CMD_CODE);
        end else if (start || shift_en) begin
            cmd_sr <= {1'b0, cmd_sr[CMD_W-1:1]};
        end
    end

    // Line value: takes the next command bit while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_q <= 1'b0;
        end else if (start || shift_en) begin
            dq_q <= cmd_sr[0];
        end
    end

    // Direction flag: drive from start until the turnaround or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (turn_en || done) begin
            oe_q <= 1'b0;
        end else if (start) begin
            oe_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rtc_capture.sv
`timescale 1ns/1ps
// Module: rtc_capture
// Shifts reply bits into a hidden chain (first bit ends at bit 0), copies
// the chain to the output latch at terminal count, and gates each latched
// byte with its own active-low enable.
module rtc_capture #(
    parameter int N_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic                 dq_in,
    input  logic                 done,
    input  logic [N_BYTES-1:0]   byte_oe_n,
    output logic [8*N_BYTES-1:0] rd_data
);
    localparam int DATA_W = 8 * N_BYTES;

    logic [DATA_W-1:0] chain;
    logic [DATA_W-1:0] latch_q;

    // Shift chain: new bit enters at the top, so earlier bits move toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (sample_en) begin
            chain <= {dq_in, chain[DATA_W-1:1]};
        end
    end

    // Output latch: updated only when the transaction finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (done) begin
            latch_q <= chain;
        end
    end

    // Per-byte output gating for display multiplexing.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        assign rd_data[8*k +: 8] = byte_oe_n[k] ? 8'h00 : latch_q[8*k +: 8];
    end

endmodule

// File: rtl/rtc_burst_reader.sv
`timescale 1ns/1ps
// Module: rtc_burst_reader
// Top of the three-wire RTC burst reader. Detects trigger edges, runs the
// idle/armed/run controller and connects the clock divider, pulse sequencer,
// command shifter and reply capture.
// Assumes trig_n is synchronous to clk and CLK_DIV is even and at least 4.
module rtc_burst_reader
    import rtc_burst_pkg::*;
#(
    parameter int         CLK_DIV  = 4,
    parameter int         CMD_W    = RTC_CMD_BITS,
    parameter int         N_BYTES  = RTC_REPLY_BYTES,
    parameter logic [7:0] CMD_CODE = RTC_BURST_CMD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_n,
    input  logic [N_BYTES-1:0]   byte_oe_n,
    input  logic                 dq_in,
    output logic                 ce,
    output logic                 sclk,
    output logic                 dq_out,
    output logic                 dq_oe,
    output logic                 busy,
    output logic [8*N_BYTES-1:0] rd_data
);
    rtc_state_e state;
    logic       trig_q;
    logic       trig_fall;
    logic       trig_rise;
    logic       run;
    logic       load;
    logic       start;
    logic       rise_tick;
    logic       fall_tick;
    logic       shift_en;
    logic       turn_en;
    logic       sample_en;
    logic       done;

    // Trigger history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b1;
        end else begin
            trig_q <= trig_n;
        end
    end

    assign trig_fall = trig_q && !trig_n;
    assign trig_rise = !trig_q && trig_n;
    assign run       = (state == ST_RUN);
    assign load      = trig_fall && !run;
    assign start     = trig_rise && (state == ST_ARMED);

    // Controller: fall arms, rise starts, terminal count returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (trig_fall) state <= ST_ARMED;
                ST_ARMED: if (trig_rise) state <= ST_RUN;
                ST_RUN:   if (done)      state <= ST_IDLE;
                default:                 state <= ST_IDLE;
            endcase
        end
    end

    assign ce   = run;
    assign busy = (state != ST_IDLE);

    rtc_sclk_gen #(
        .CLK_DIV (CLK_DIV)
    ) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    rtc_pulse_seq #(
        .CMD_W   (CMD_W),
        .N_BYTES (N_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .shift_en  (shift_en),
        .turn_en   (turn_en),
        .sample_en (sample_en),
        .done      (done)
    );

    rtc_cmd_shifter #(
        .CMD_W    (CMD_W),
        .CMD_CODE (CMD_CODE)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start    (start),
        .shift_en (shift_en),
        .turn_en  (turn_en),
        .done     (done),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    rtc_capture #(
        .N_BYTES (N_BYTES)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .dq_in     (dq_in),
        .done      (done),
        .byte_oe_n (byte_oe_n),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/rtc_burst_reader_chk.sv
`timescale 1ns/1ps
// Module: rtc_burst_reader_chk
// Port-level protocol checker bound to rtc_burst_reader. Counts serial clock
// rises per chip-enable window with its own counter instead of deep $past.
module rtc_burst_reader_chk #(
    parameter int CMD_W   = 8,
    parameter int N_BYTES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce,
    input logic                 sclk,
    input logic                 dq_out,
    input logic                 dq_oe,
    input logic                 busy,
    input logic [N_BYTES-1:0]   byte_oe_n,
    input logic [8*N_BYTES-1:0] rd_data
);
    localparam int TOTAL = CMD_W + 8 * N_BYTES;
    localparam int CW    = $clog2(TOTAL + 2);

    logic          sclk_d;
    logic [CW-1:0] rise_cnt;

    // Rise counter for the current chip-enable window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            if (!ce) begin
                rise_cnt <= '0;
            end else if (sclk && !sclk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    assert_sclk_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> ce);
    assert_pulse_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce) |-> (rise_cnt == CW'(TOTAL)));
    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= CW'(TOTAL));
    assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(dq_out));
    assert_release_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> $rose(sclk));
    assert_drive_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ce);
    assert_latch_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(byte_oe_n)) |-> $stable(rd_data));
    assert_busy_covers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce |-> busy);

endmodule

bind rtc_burst_reader rtc_burst_reader_chk #(
    .CMD_W   (CMD_W),
    .N_BYTES (N_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .sclk      (sclk),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .busy      (busy),
    .byte_oe_n (byte_oe_n),
    .rd_data   (rd_data)
);

// File: tb/rtc_burst_reader_test.sv
`timescale 1ns/1ps
// Bench for rtc_burst_reader: a peripheral model on the serial bus, a
// vector table of replies and byte masks, then directed corner cases.
module rtc_burst_reader_test;
    localparam int DIV = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_n = 1'b1;
    logic [7:0]  byte_oe_n = 8'h00;
    logic        dq_in = 1'b0;
    logic        ce, sclk, dq_out, dq_oe, busy;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [63:0] cur_reply = '0;

    // Peripheral-side observations, written only by the monitor.
    int         rises = 0;
    int         falls = 0;
    int         ce_cyc = 0;
    int         oe_err = 0;
    int         hi_chg = 0;
    logic [7:0] cmd_got = '0;
    logic       ce_p = 1'b0;
    logic       sclk_p = 1'b0;
    logic       dq_p = 1'b0;

    rtc_burst_reader #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .byte_oe_n(byte_oe_n),
        .dq_in(dq_in), .ce(ce), .sclk(sclk), .dq_out(dq_out), .dq_oe(dq_oe),
        .busy(busy), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    // Peripheral model, sampled on the falling system clock edge.
    always @(negedge clk) begin
        if (ce && !ce_p) begin
            rises = 0; falls = 0; ce_cyc = 0; oe_err = 0; hi_chg = 0; cmd_got = '0;
        end
        if (ce) ce_cyc = ce_cyc + 1;
        if (sclk && sclk_p && (dq_out !== dq_p)) hi_chg = hi_chg + 1;
        if (sclk && !sclk_p) begin
            rises = rises + 1;
            if (dq_oe !== (rises <= 8)) oe_err = oe_err + 1;
            if (rises <= 8) cmd_got[rises-1] = dq_out;
        end
        if (!sclk && sclk_p) begin
            falls = falls + 1;
            if (falls >= 8 && falls < 72) dq_in = cur_reply[falls-8];
        end
        ce_p = ce; sclk_p = sclk; dq_p = dq_out;
    end

    function automatic logic [63:0] gated(input logic [63:0] d, input logic [7:0] m);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) if (!m[k]) r[8*k +: 8] = d[8*k +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Trigger pulse with the R2 arming and start checks.
    task automatic trigger(input logic [63:0] reply);
        cur_reply = reply;
        @(negedge clk) trig_n = 1'b0;
        @(negedge clk);
        chk("R2 busy after trigger fall", 64'(busy), 64'd1);
        chk("R2 ce low while armed", 64'(ce), 64'd0);
        trig_n = 1'b1;
        @(negedge clk);
        chk("R2 ce after trigger rise", 64'(ce), 64'd1);
    endtask

    task automatic wait_end();
        int n = 0;
        while (ce && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic txn_checks(input logic [63:0] reply, input logic [7:0] m);
        chk("R3 sclk rise count", 64'(rises), 64'd72);
        chk("R3 ce high cycles", 64'(ce_cyc), 64'(72 * DIV));
        chk("R4 command byte", 64'(cmd_got), 64'hBF);
        chk("R4 dq_out changes while sclk high", 64'(hi_chg), 64'd0);
        chk("R5 drive enable by pulse", 64'(oe_err), 64'd0);
        chk("R10 busy low after end", 64'(busy), 64'd0);
        chk("R6 R8 reply bytes", rd_data, gated(reply, m));
    endtask

    localparam logic [71:0] VEC [5] = '{
        {64'h0123_4567_89AB_CDEF, 8'h00},
        {64'hFFFF_FFFF_FFFF_FFFF, 8'h00},
        {64'h0000_0000_0000_0000, 8'h00},
        {64'hA5C3_1E7F_8000_0001, 8'hFE},
        {64'h5A5A_F00F_3CC3_9669, 8'h55}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ce", 64'(ce), 64'd0);
        chk("R1 sclk", 64'(sclk), 64'd0);
        chk("R1 dq_oe", 64'(dq_oe), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 rd_data", rd_data, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk: R3 R4 R5 R6 R8 R10 per transaction.
        for (int i = 0; i < 5; i++) begin
            byte_oe_n = VEC[i][7:0];
            trigger(VEC[i][71:8]);
            wait_end();
            @(negedge clk);
            txn_checks(VEC[i][71:8], VEC[i][7:0]);
        end

        // R7 and R9: output frozen mid-run, retrigger ignored.
        byte_oe_n = 8'h00;
        trigger(64'hDEAD_BEEF_CAFE_F00D);
        wait_end();
        @(negedge clk);
        trigger(64'h1357_9BDF_2468_ACE0);
        while (rises < 30) @(negedge clk);
        chk("R7 rd_data held mid-transaction", rd_data, 64'hDEAD_BEEF_CAFE_F00D);
        trig_n = 1'b0;
        @(negedge clk) trig_n = 1'b1;
        while (rises < 71) @(negedge clk);
        chk("R7 rd_data held before last pulse", rd_data, 64'hDEAD_BEEF_CAFE_F00D);
        wait_end();
        chk("R7 rd_data updated at end", rd_data, 64'h1357_9BDF_2468_ACE0);
        chk("R9 pulse count with retrigger", 64'(rises), 64'd72);
        begin
            int hi = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (ce || busy) hi++;
            end
            chk("R9 no transaction after ignored trigger", 64'(hi), 64'd0);
        end

        // R8: one byte selected at a time.
        for (int k = 0; k < 8; k++) begin
            byte_oe_n = ~(8'h01 << k);
            @(negedge clk);
            chk("R8 single byte select", rd_data, gated(64'h1357_9BDF_2468_ACE0, ~(8'h01 << k)));
        end
        byte_oe_n = 8'hFF;
        @(negedge clk);
        chk("R8 all bytes disabled", rd_data, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R3 act=timeout exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule